// File: doc/BRIEF.md
# Segmented Set-Before-First Mask Unit

This block turns a source word into a predicate mask. It walks the source from bit 0 upward. While it is filling, every position whose source bit is clear is set in the result. The first set source bit ends the fill, and that bit stays clear in the result. With no restart word, the result is the run of ones that lies below the lowest set source bit.

A second word, the restart mask, can be enabled beside the source. When it is enabled, filling is active at bit 0 only if mask bit 0 is set. Any set mask bit turns filling back on at its own position. This lets one operation fill several separate segments of the result.

One request is taken per cycle, marked by a valid strobe. The result appears one clock later with its own valid strobe and is held until the next request. A parameter sets the word width. A second parameter chooses between a serial ripple chain and a logarithmic parallel-prefix network for the scan.

Top module: `segfill_mask_unit`

## Requirements
- R1: With the restart mask disabled, result bit i is 1 exactly when source bits 0..i are all 0; for example, an 8-bit source of 8'b1001_0100 gives 8'b0000_0011.
- R2: With the restart mask disabled, an all-zero source gives an all-ones result.
- R3: With the restart mask disabled, a source with bit 0 set gives an all-zero result.
- R4: With the restart mask enabled, filling is active at bit 0 only if mask bit 0 is 1, so an all-zero mask always gives an all-zero result.
- R5: With the restart mask enabled, a mask bit of 1 at position i turns filling on, and position i is evaluated in the same step. Mask 8'b1100_0011 with source 8'b1001_0100 gives 8'b0100_0011.
- R6: A result bit is never set where the source bit is set. This holds even when the mask bit at that position is also set: filling starts and stops at once.
- R7: When the restart mask is disabled, its value has no effect on the result.
- R8: out_valid is high in exactly the cycle after each cycle in which in_valid is high. out_word changes only in that cycle and holds its value otherwise.
- R9: Driving rst_n low clears out_valid at once, without waiting for a clock edge. The reset is released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| src_word | input | W | Source word that is scanned from bit 0 upward |
| restart_mask | input | W | Positions where filling restarts |
| mask_en | input | 1 | 1: use restart_mask; 0: ignore it and start filling at bit 0 |
| out_valid | output | 1 | out_word holds the result of the request from the previous cycle |
| out_word | output | W | Registered result mask |

## Verification
The all-zero source, the all-one source, and sources with only bit 0 set show whether the fill starts at bit 0 and where it stops. The worked examples check the exact boundary of a single run and of a restarted run. Masks whose set bits coincide with set source bits show whether a restart and a stop at the same position resolve to a clear bit. Random source and mask words, including sparse masks that create many short segments, are compared bit for bit against a serial model. Each word is applied with the mask enabled and disabled, at 64-bit width with the prefix network and at 8-bit width with the ripple chain. Reusing the same source with different disabled masks shows whether a disabled mask leaks into the result.

// File: rtl/segfill_pkg.sv
package segfill_pkg;

  // Structure of the scan that resolves the fill state across the word
  typedef enum logic [0:0] {
    SCAN_RIPPLE = 1'b0,
    SCAN_PREFIX = 1'b1
  } scan_style_e;

endpackage

// File: rtl/segfill_seed.sv
// Per-bit generate/propagate terms for the fill scan.
// Filling leaving bit i = gen[i] | (prop[i] & filling leaving bit i-1).
// The start state at bit 0 (filling when the mask is disabled) is folded into gen[0].
module segfill_seed #(
  parameter int W = 64
) (
  input  logic [W-1:0] src_word,
  input  logic [W-1:0] restart_mask,
  input  logic         mask_en,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == 0) begin : g_lsb
      assign gen[b] = ~src_word[b] & (~mask_en | restart_mask[b]);
    end else begin : g_upper
      assign gen[b] = ~src_word[b] & mask_en & restart_mask[b];
    end
    assign prop[b] = ~src_word[b];
  end

endmodule

// File: rtl/segfill_scan.sv
// Resolves the fill state at every bit from the generate/propagate terms.
module segfill_scan
  import segfill_pkg::*;
#(
  parameter int          W     = 64,
  parameter scan_style_e STYLE = SCAN_PREFIX
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] prop,
  output logic [W-1:0] fill
);

  localparam int LEVELS = (W > 1) ? $clog2(W) : 0;

  if (STYLE == SCAN_RIPPLE) begin : g_ripple
    logic acc;
    always_comb begin
      acc  = 1'b0;
      fill = '0;
      for (int b = 0; b < W; b++) begin
        acc     = gen[b] | (prop[b] & acc);
        fill[b] = acc;
      end
    end
  end else begin : g_prefix
    // Logarithmic prefix network; each level doubles the span it combines
    logic [W-1:0] g_cur, p_cur, g_nxt, p_nxt;
    always_comb begin
      g_cur = gen;
      p_cur = prop;
      g_nxt = gen;
      p_nxt = prop;
      for (int lv = 0; lv < LEVELS; lv++) begin
        g_nxt = g_cur;
        p_nxt = p_cur;
        for (int b = (1 << lv); b < W; b++) begin
          g_nxt[b] = g_cur[b] | (p_cur[b] & g_cur[b - (1 << lv)]);
          p_nxt[b] = p_cur[b] & p_cur[b - (1 << lv)];
        end
        g_cur = g_nxt;
        p_cur = p_nxt;
      end
      fill = g_cur;
    end
  end

endmodule

// File: rtl/segfill_out_reg.sv
// Output stage: the valid flag follows the input each cycle, and the word loads only on a request.
module segfill_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] next_word,
  output logic         vld_q,
  output logic [W-1:0] word_q
);

  logic         vld_d;
  logic [W-1:0] word_d;

  always_comb begin
    vld_d  = load;
    word_d = word_q;
    if (load) begin
      word_d = next_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/segfill_mask_unit.sv
module segfill_mask_unit
  import segfill_pkg::*;
#(
  parameter int          W     = 64,
  parameter scan_style_e STYLE = SCAN_PREFIX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] src_word,
  input  logic [W-1:0] restart_mask,
  input  logic         mask_en,
  output logic         out_valid,
  output logic [W-1:0] out_word
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W-1:0] fill;

  segfill_seed #(.W(W)) u_seed (
    .src_word     (src_word),
    .restart_mask (restart_mask),
    .mask_en      (mask_en),
    .gen          (gen),
    .prop         (prop)
  );

  segfill_scan #(.W(W), .STYLE(STYLE)) u_scan (
    .gen  (gen),
    .prop (prop),
    .fill (fill)
  );

  segfill_out_reg #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (in_valid),
    .next_word (fill),
    .vld_q     (out_valid),
    .word_q    (out_word)
  );

endmodule

// File: rtl/segfill_mask_unit_chk.sv
module segfill_mask_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] src_word,
  input logic [W-1:0] restart_mask,
  input logic         mask_en,
  input logic         out_valid,
  input logic [W-1:0] out_word
);

  logic         seen;
  logic [W-1:0] cap_src;
  logic [W-1:0] cap_mask;
  logic         cap_en;
  logic [W-1:0] word_inc;

  // seen is 1 once at least one clock edge has passed with reset released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      cap_src  <= src_word;
      cap_mask <= restart_mask;
      cap_en   <= mask_en;
    end
  end

  assign word_inc = out_word + {{(W-1){1'b0}}, 1'b1};

  assert_run_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_en) |-> ((out_word & word_inc) == '0));

  assert_all_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_en && cap_src == '0) |-> (out_word == '1));

  assert_bit0_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_en && cap_src[0]) |-> (out_word == '0));

  assert_zero_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_en && cap_mask == '0) |-> (out_word == '0));

  assert_restart_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_en) |-> ((out_word & ~(cap_mask | (out_word << 1))) == '0));

  assert_no_src_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_word & cap_src) == '0));

  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (out_valid == $past(in_valid)));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(in_valid)) |-> $stable(out_word));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

bind segfill_mask_unit segfill_mask_unit_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .src_word     (src_word),
  .restart_mask (restart_mask),
  .mask_en      (mask_en),
  .out_valid    (out_valid),
  .out_word     (out_word)
);

// File: tb/segfill_mask_unit_bench.sv
module segfill_mask_unit_bench;
  import segfill_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src;
  logic [63:0] msk;
  logic        en;
  logic        ov64;
  logic [63:0] ow64;
  logic        ov8;
  logic [7:0]  ow8;

  int n_checks;
  int n_fail;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  segfill_mask_unit #(.W(64), .STYLE(SCAN_PREFIX)) u_segfill_mask_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .src_word (src), .restart_mask (msk), .mask_en (en),
    .out_valid (ov64), .out_word (ow64)
  );

  segfill_mask_unit #(.W(8), .STYLE(SCAN_RIPPLE)) u_segfill_mask_unit_w8 (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .src_word (src[7:0]), .restart_mask (msk[7:0]), .mask_en (en),
    .out_valid (ov8), .out_word (ow8)
  );

  // Serial model of the scan, written from the requirements
  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] m,
                                        input logic e, input int w);
    logic        filling;
    logic [63:0] r;
    r       = '0;
    filling = !e;
    for (int i = 0; i < w; i++) begin
      if (e && m[i]) filling = 1'b1;
      if (filling) begin
        if (s[i]) filling = 1'b0;
        else      r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [63:0] s, input logic e, input int w);
    logic [63:0] sw;
    sw = (w == 8) ? {56'd0, s[7:0]} : s;
    if (e)            return "R5";
    if (sw == '0)     return "R2";
    if (sw[0])        return "R3";
    return "R1";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; the result is sampled at the negedge after the capturing posedge
  task automatic run_op(input logic [63:0] s, input logic [63:0] m, input logic e);
    @(negedge clk);
    src = s; msk = m; en = e; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", {63'd0, ov64}, 64'd1);
    chk(tag_of(s, e, 64), ow64, model(s, m, e, 64));
    chk(tag_of(s, e, 8), {56'd0, ow8}, model(s, m, e, 8));
  endtask

  logic [63:0] held;
  logic [63:0] r1;
  logic [63:0] r2;

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    src = '0; msk = '0; en = 1'b0;
    void'($urandom(32'h5E6F_11A5));
    repeat (3) @(negedge clk);
    chk("R9", {63'd0, ov64}, 64'd0);
    chk("R9", {63'd0, ov8}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", {63'd0, ov64}, 64'd0);

    // Directed corner cases
    run_op(64'h94, 64'h0, 1'b0);                  // R1 worked example
    chk("R1", {56'd0, ow8}, 64'h03);
    run_op(64'h0, 64'h0, 1'b0);                   // R2
    run_op(64'h95, 64'h0, 1'b0);                  // R3
    run_op('1, 64'h0, 1'b0);                      // R3 all ones
    run_op(64'h94, 64'hC3, 1'b1);                 // R5 worked example
    chk("R5", {56'd0, ow8}, 64'h43);
    run_op(64'h0, 64'h0, 1'b1);                   // R4 empty mask
    chk("R4", ow64, 64'h0);
    run_op(64'h0, 64'h2, 1'b1);                   // R4 fill starts late
    chk("R4", ow64, 64'hFFFF_FFFF_FFFF_FFFE);
    run_op(64'h0, 64'h1, 1'b1);                   // R5 start at bit 0
    chk("R5", ow64, '1);
    run_op(64'h04, 64'h04, 1'b1);                 // R6 restart and stop together
    chk("R6", ow64, 64'h0);
    run_op('1, '1, 1'b1);                         // R6 every bit collides
    chk("R6", ow64, 64'h0);
    run_op(64'h0, '1, 1'b1);                      // R5 all restarts
    chk("R5", ow64, '1);

    // R8: no request, so valid drops and the word holds
    held = ow64;
    @(negedge clk);
    chk("R8", {63'd0, ov64}, 64'd0);
    chk("R8", ow64, held);

    // R7: a disabled mask has no effect
    for (int k = 0; k < 20; k++) begin
      logic [63:0] s;
      s = {$urandom, $urandom} & {$urandom, $urandom};
      run_op(s, {$urandom, $urandom}, 1'b0);
      r1 = ow64;
      run_op(s, 64'h0, 1'b0);
      chk("R7", r1, ow64);
    end

    // Random words, dense and sparse, both mask settings
    for (int k = 0; k < 300; k++) begin
      logic [63:0] s;
      logic [63:0] m;
      s = {$urandom, $urandom};
      m = {$urandom, $urandom};
      if (k % 3 == 0) s = s & {$urandom, $urandom} & {$urandom, $urandom};
      if (k % 4 == 1) m = m & {$urandom, $urandom};
      if (k % 5 == 2) s = s << ($urandom % 64);
      run_op(s, m, k[0]);
    end

    // R9: asynchronous reset drops valid before any clock edge
    @(negedge clk);
    src = 64'h10; msk = '0; en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", {63'd0, ov64}, 64'd1);
    #1 rst_n = 1'b0;
    #1;
    chk("R9", {63'd0, ov64}, 64'd0);
    chk("R9", {63'd0, ov8}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(64'h80, 64'h0, 1'b0);
    r2 = ow64;
    chk("R1", r2, 64'h7F);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule